// File: doc/BRIEF.md
# Fade and Level Gain Sequencer

This block owns the digital gain code of a stereo recording path. The code is 8 bits wide, one step is 0.375 dB, 00h is mute and F1h is the largest code the block will produce. Three kinds of change reach the code. A fade-in ramps the code up toward a reference level. A fade-out ramps it down to mute. A manual write replaces it with a software value that is never allowed above the reference. Both channels share the single code, so left and right always move together.

No change reaches the output directly. Each one first becomes a pending value. The pending value is committed when the path reports a zero crossing, or when a selectable timeout runs out, whichever comes first. All time is counted in sample-rate ticks, and the parameter `TICKS_PER_MS` gives the number of ticks in one millisecond. Fades advance by a selectable number of codes at a selectable interval. When automatic level control is switched off, the last manual value returns, but only through the timeout path.

Top module: `fade_gain_seq`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `gain_code` is 00h and `done` is 0.
- R2: A rising edge on `fade_in_en` starts a fade-in and clears `done`. Each fade step raises the code by the step size and never goes past the reference. Once the committed code equals the reference, `done` goes to 1. The step-size field `fade_step_sel` encodes 00 = 1 code, 01 = 2, 10 = 4 and 11 = 8.
- R3: The fade period is selected by `fade_period_sel`: 00 = 20 ms, 01 = 40 ms, 10 = 48 ms and 11 = 56 ms. The first step is requested exactly that many ticks after the start edge, and later steps follow at the same interval.
- R4: A rising edge on `fade_out_en` starts a fade-out, which lowers the code by the step size each period. The code saturates at 00h without wrapping, and `done` goes to 1 once the committed code is 00h.
- R5: A pending change is copied to `gain_code` at the clock edge that samples `zc_strobe` high.
- R6: Without a zero crossing, a pending change is committed when the timeout ends. The timeout is counted from the most recent request and is selected by `zc_tmo_sel`: 00 = 8 ms, 01 = 16 ms, 10 = 32 ms and 11 = 64 ms.
- R7: A manual write (`man_wr` with `auto_en` low and no fade running) requests min(`man_code`, reference). A reference above F1h is treated as F1h, so `gain_code` never exceeds F1h.
- R8: A falling edge on `auto_en` requests the most recently written manual value, clamped to the reference. This request ignores `zc_strobe` and commits only when the timeout ends.
- R9: A manual write made while `auto_en` is high leaves `gain_code` unchanged. The value is only stored.
- R10: When a zero crossing arrives on the same edge as a fade step, the older pending value is committed, and the new step value becomes the next pending value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_tick | input | 1 | One-cycle pulse per audio sample; the time base |
| ref_code | input | 8 | Reference (target) gain code |
| man_code | input | 8 | Manual gain value |
| man_wr | input | 1 | Write strobe for `man_code` |
| auto_en | input | 1 | Automatic level control active |
| fade_in_en | input | 1 | Fade-in enable; the rising edge starts a fade-in |
| fade_out_en | input | 1 | Fade-out enable; the rising edge starts a fade-out |
| fade_period_sel | input | 2 | Fade step period select |
| fade_step_sel | input | 2 | Codes moved per fade step |
| zc_strobe | input | 1 | Zero-crossing detected |
| zc_tmo_sel | input | 2 | Zero-crossing timeout select |
| gain_code | output | 8 | Committed gain code for both channels |
| done | output | 1 | The last fade reached its end level |

## Verification
Two events can fall in the same cycle: a zero-crossing commit and a new fade step. The bench provokes this by choosing a timeout longer than the fade period, so the first step is still pending when the second step fires. It then pulses `zc_strobe` on exactly the edge where the second step is requested. The result is correct when the code shows the first step's value on that edge, holds it afterwards, and shows the second value only at the next crossing. A second pairing is a zero-crossing pulse that lands on a request made when automatic control turns off; that case is judged by the code staying unchanged until the timeout ends.

// File: rtl/gseq_pkg.sv
package gseq_pkg;

    localparam logic [7:0] GAIN_MUTE = 8'h00;
    localparam logic [7:0] GAIN_TOP  = 8'hF1;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RISE = 2'd1,
        SEQ_FALL = 2'd2
    } seq_mode_e;

    typedef struct packed {
        logic       valid;
        logic       tmo_only;
        logic [7:0] code;
    } gain_req_s;

    function automatic logic [7:0] step_codes(input logic [1:0] sel);
        return 8'd1 << sel;
    endfunction

    function automatic int unsigned fade_ms(input logic [1:0] sel);
        case (sel)
            2'd0:    return 20;
            2'd1:    return 40;
            2'd2:    return 48;
            default: return 56;
        endcase
    endfunction

    function automatic int unsigned tmo_ms(input logic [1:0] sel);
        return 32'd8 << sel;
    endfunction

    function automatic logic [7:0] min8(input logic [7:0] a, input logic [7:0] b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/gseq_tick_timer.sv
module gseq_tick_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          load,
    input  logic          run,
    input  logic [CW-1:0] reload,
    output logic          expire
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= reload;
        end else if (run && tick) begin
            cnt_q <= (cnt_q == '0) ? reload : cnt_q - CW'(1);
        end
    end

    always_comb expire = run && tick && (cnt_q == '0);

    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (run && tick && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CW'(1)));

endmodule

// File: rtl/gseq_ramp.sv
module gseq_ramp (
    input  logic [7:0] base,
    input  logic [7:0] limit,
    input  logic [7:0] step,
    input  logic       down,
    output logic [7:0] nxt
);
    logic [8:0] sum;

    always_comb begin
        sum = {1'b0, base} + {1'b0, step};
        if (down) begin
            nxt = (base <= step) ? 8'h00 : base - step;
        end else if (base >= limit || sum >= {1'b0, limit}) begin
            nxt = limit;
        end else begin
            nxt = sum[7:0];
        end
    end
endmodule

// File: rtl/fade_gain_seq.sv
module fade_gain_seq
    import gseq_pkg::*;
#(
    parameter int TICKS_PER_MS = 48
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       smp_tick,
    input  logic [7:0] ref_code,
    input  logic [7:0] man_code,
    input  logic       man_wr,
    input  logic       auto_en,
    input  logic       fade_in_en,
    input  logic       fade_out_en,
    input  logic [1:0] fade_period_sel,
    input  logic [1:0] fade_step_sel,
    input  logic       zc_strobe,
    input  logic [1:0] zc_tmo_sel,
    output logic [7:0] gain_code,
    output logic       done
);
    localparam int MAX_TICKS = 64 * TICKS_PER_MS;
    localparam int CW        = $clog2(MAX_TICKS + 1);
    localparam int N_TMR     = 2;
    localparam int T_STEP    = 0;
    localparam int T_ZC      = 1;

    seq_mode_e  mode_q;
    gain_req_s  pend_q;
    gain_req_s  req;
    logic [7:0] gain_q;
    logic [7:0] man_q;
    logic       done_q;
    logic       fin_q, fout_q, auto_q;

    logic       fin_rise, fout_rise, auto_fall;
    logic [7:0] ref_eff, base, ramp_nxt;
    logic       commit, step_exp, tmo_exp;

    logic [N_TMR-1:0] t_load, t_run, t_exp;
    logic [CW-1:0]    t_reload [N_TMR];

    always_comb begin
        fin_rise  = fade_in_en && !fin_q;
        fout_rise = fade_out_en && !fout_q;
        auto_fall = !auto_en && auto_q;
        ref_eff   = min8(ref_code, GAIN_TOP);
        base      = pend_q.valid ? pend_q.code : gain_q;
    end

    gseq_ramp u_ramp (
        .base  (base),
        .limit (ref_eff),
        .step  (step_codes(fade_step_sel)),
        .down  (mode_q == SEQ_FALL),
        .nxt   (ramp_nxt)
    );

    always_comb begin
        t_reload[T_STEP] = CW'(fade_ms(fade_period_sel) * TICKS_PER_MS - 1);
        t_reload[T_ZC]   = CW'(tmo_ms(zc_tmo_sel) * TICKS_PER_MS - 1);
        t_load[T_STEP]   = (mode_q == SEQ_IDLE) && (fin_rise || fout_rise);
        t_run[T_STEP]    = (mode_q != SEQ_IDLE);
        t_load[T_ZC]     = req.valid;
        t_run[T_ZC]      = pend_q.valid;
        step_exp         = t_exp[T_STEP];
        tmo_exp          = t_exp[T_ZC];
    end

    for (genvar gi = 0; gi < N_TMR; gi++) begin : g_tmr
        gseq_tick_timer #(.CW(CW)) u_tmr (
            .clk    (clk),
            .rst    (rst),
            .tick   (smp_tick),
            .load   (t_load[gi]),
            .run    (t_run[gi]),
            .reload (t_reload[gi]),
            .expire (t_exp[gi])
        );
    end

    always_comb begin
        req = '0;
        if (mode_q != SEQ_IDLE) begin
            if (step_exp && ramp_nxt != base) begin
                req = '{valid: 1'b1, tmo_only: 1'b0, code: ramp_nxt};
            end
        end else if (man_wr && !auto_en) begin
            req = '{valid: 1'b1, tmo_only: 1'b0, code: min8(man_code, ref_eff)};
        end else if (auto_fall) begin
            req = '{valid: 1'b1, tmo_only: 1'b1, code: min8(man_q, ref_eff)};
        end
        commit = pend_q.valid && ((zc_strobe && !pend_q.tmo_only) || tmo_exp);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= SEQ_IDLE;
            pend_q <= '0;
            gain_q <= GAIN_MUTE;
            man_q  <= '0;
            done_q <= 1'b0;
            fin_q  <= 1'b0;
            fout_q <= 1'b0;
            auto_q <= 1'b0;
        end else begin
            fin_q  <= fade_in_en;
            fout_q <= fade_out_en;
            auto_q <= auto_en;
            if (man_wr) begin
                man_q <= man_code;
            end
            if (commit) begin
                gain_q       <= pend_q.code;
                pend_q.valid <= 1'b0;
            end
            if (req.valid) begin
                pend_q <= req;
            end
            case (mode_q)
                SEQ_IDLE: begin
                    if (fout_rise) begin
                        mode_q <= SEQ_FALL;
                        done_q <= 1'b0;
                    end else if (fin_rise) begin
                        mode_q <= SEQ_RISE;
                        done_q <= 1'b0;
                    end
                end
                SEQ_RISE: begin
                    if (!pend_q.valid && gain_q == ref_eff) begin
                        mode_q <= SEQ_IDLE;
                        done_q <= 1'b1;
                    end
                end
                SEQ_FALL: begin
                    if (!pend_q.valid && gain_q == GAIN_MUTE) begin
                        mode_q <= SEQ_IDLE;
                        done_q <= 1'b1;
                    end
                end
                default: mode_q <= SEQ_IDLE;
            endcase
        end
    end

    always_comb begin
        gain_code = gain_q;
        done      = done_q;
    end

    // R7
    gain_cap_chk: assert property (@(posedge clk) disable iff (rst)
        gain_q <= GAIN_TOP);

    // R5
    zc_commit_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_q.valid && !pend_q.tmo_only && zc_strobe) |=> (gain_q == $past(pend_q.code)));

    // R8
    zc_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_q.valid && pend_q.tmo_only && zc_strobe && !tmo_exp) |=> (gain_q == $past(gain_q)));

    // R9
    auto_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (auto_en && mode_q == SEQ_IDLE && !pend_q.valid) |=> (gain_q == $past(gain_q)));

    // R2 R4
    done_level_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done_q) |-> (gain_q == GAIN_MUTE || gain_q == ref_eff));

endmodule

// File: tb/test_fade_gain_seq.sv
module test_fade_gain_seq;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       smp_tick = 1'b1;
    logic [7:0] ref_code = '0;
    logic [7:0] man_code = '0;
    logic       man_wr = 1'b0;
    logic       auto_en = 1'b0;
    logic       fade_in_en = 1'b0;
    logic       fade_out_en = 1'b0;
    logic [1:0] fade_period_sel = '0;
    logic [1:0] fade_step_sel = '0;
    logic       zc_strobe = 1'b0;
    logic [1:0] zc_tmo_sel = '0;
    logic [7:0] gain_code;
    logic       done;

    int checks = 0;
    int failures = 0;
    bit finished = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] last_gain = 8'h00;

    always #4 clk = ~clk;

    fade_gain_seq #(.TICKS_PER_MS(1)) i_fade_gain_seq (
        .clk(clk), .rst(rst), .smp_tick(smp_tick), .ref_code(ref_code),
        .man_code(man_code), .man_wr(man_wr), .auto_en(auto_en),
        .fade_in_en(fade_in_en), .fade_out_en(fade_out_en),
        .fade_period_sel(fade_period_sel), .fade_step_sel(fade_step_sel),
        .zc_strobe(zc_strobe), .zc_tmo_sel(zc_tmo_sel),
        .gain_code(gain_code), .done(done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic expect_gain(input logic [7:0] v, input string req);
        exp_q.push_back(v);
        tag_q.push_back(req);
    endtask

    // scoreboard monitor: every change of gain_code is popped and compared
    always @(negedge clk) begin
        if (rst) begin
            last_gain = 8'h00;
        end else if (gain_code !== last_gain) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "SB-unexpected", gain_code, last_gain);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(gain_code == e, t, gain_code, e);
            end
            last_gain = gain_code;
        end
    end

    task automatic adv(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic man_write(input logic [7:0] v);
        man_code = v;
        man_wr = 1'b1;
        @(negedge clk);
        man_wr = 1'b0;
    endtask

    task automatic zc_pulse();
        zc_strobe = 1'b1;
        @(negedge clk);
        zc_strobe = 1'b0;
    endtask

    task automatic wait_done(input int limit);
        for (int i = 0; i < limit && !done; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        adv(3);
        rst = 1'b0;
        adv(1);
        // R1
        check(gain_code == 8'h00, "R1 gain", gain_code, 8'h00);
        check(done == 1'b0, "R1 done", done, 0);

        // R7 clamp to reference, R6 8-tick timeout
        ref_code = 8'h40;
        zc_tmo_sel = 2'd0;
        expect_gain(8'h40, "R7 clamp");
        man_write(8'h80);
        adv(7);
        check(gain_code == 8'h00, "R6 before timeout", gain_code, 8'h00);
        adv(1);
        check(gain_code == 8'h40, "R6 at timeout", gain_code, 8'h40);

        // R7 reference above top code, R5 zero-cross commit
        ref_code = 8'hFF;
        expect_gain(8'hF1, "R7 top");
        man_write(8'hFF);
        zc_pulse();
        check(gain_code == 8'hF1, "R5 zc commit", gain_code, 8'hF1);

        // R9 write held while automatic control is on
        auto_en = 1'b1;
        adv(1);
        man_write(8'h1D);
        adv(20);
        check(gain_code == 8'hF1, "R9 hold", gain_code, 8'hF1);

        // R8 release after auto off: timeout only, zc ignored
        zc_tmo_sel = 2'd1;
        expect_gain(8'h1D, "R8 return");
        auto_en = 1'b0;
        adv(1);
        zc_strobe = 1'b1;
        adv(3);
        zc_strobe = 1'b0;
        adv(12);
        check(gain_code == 8'hF1, "R8 zc ignored", gain_code, 8'hF1);
        adv(1);
        check(gain_code == 8'h1D, "R8 timeout", gain_code, 8'h1D);

        // R3 40-tick period, R4 fade-out with saturation at mute
        ref_code = 8'h40;
        zc_tmo_sel = 2'd0;
        fade_period_sel = 2'd1;
        fade_step_sel = 2'd3;
        expect_gain(8'h15, "R4 step");
        expect_gain(8'h0D, "R4 step");
        expect_gain(8'h05, "R4 step");
        expect_gain(8'h00, "R4 saturate");
        fade_out_en = 1'b1;
        adv(1);
        adv(47);
        check(gain_code == 8'h1D, "R3 before first step", gain_code, 8'h1D);
        adv(1);
        check(gain_code == 8'h15, "R3 first step", gain_code, 8'h15);
        wait_done(1000);
        adv(1);
        check(done == 1'b1, "R4 done", done, 1);
        check(gain_code == 8'h00, "R4 end level", gain_code, 8'h00);
        fade_out_en = 1'b0;

        // R2 fade-in, step 4, saturating at reference
        ref_code = 8'h0A;
        fade_period_sel = 2'd0;
        fade_step_sel = 2'd2;
        expect_gain(8'h04, "R2 step");
        expect_gain(8'h08, "R2 step");
        expect_gain(8'h0A, "R2 saturate");
        fade_in_en = 1'b1;
        adv(1);
        check(done == 1'b0, "R2 done cleared", done, 0);
        wait_done(1000);
        adv(1);
        check(done == 1'b1, "R2 done", done, 1);
        check(gain_code == 8'h0A, "R2 end level", gain_code, 8'h0A);
        fade_in_en = 1'b0;

        // back to mute
        fade_step_sel = 2'd3;
        expect_gain(8'h02, "R4 step");
        expect_gain(8'h00, "R4 saturate");
        fade_out_en = 1'b1;
        adv(1);
        wait_done(1000);
        adv(1);
        fade_out_en = 1'b0;

        // R10 zero crossing on the same edge as a fade step
        ref_code = 8'h03;
        fade_period_sel = 2'd0;
        fade_step_sel = 2'd0;
        zc_tmo_sel = 2'd3;
        expect_gain(8'h01, "R10 older commit");
        expect_gain(8'h02, "R10 newer pending");
        expect_gain(8'h03, "R2 final");
        fade_in_en = 1'b1;
        adv(1);
        adv(39);
        check(gain_code == 8'h00, "R10 nothing yet", gain_code, 8'h00);
        zc_pulse();
        check(gain_code == 8'h01, "R10 commit older", gain_code, 8'h01);
        adv(5);
        check(gain_code == 8'h01, "R10 newer held", gain_code, 8'h01);
        zc_pulse();
        check(gain_code == 8'h02, "R10 newer commit", gain_code, 8'h02);
        zc_strobe = 1'b1;
        wait_done(1000);
        zc_strobe = 1'b0;
        adv(2);
        check(done == 1'b1 && gain_code == 8'h03, "R2 done at ref", gain_code, 8'h03);
        fade_in_en = 1'b0;

        check(exp_q.size() == 0, "SB-drained", exp_q.size(), 0);
        finish_run();
    end
endmodule